// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the memory-mapped configuration slave of a color LCD controller. A processor reaches it through a simple synchronous bus and a 4 KB window of word-aligned offsets. The block holds the panel timing words, the two frame base addresses, the interrupt mask and the control word. Read data appears one cycle after the request.

From the stored words it produces the values the display pipeline needs:

- the active pixels per line and lines per panel, decoded from packed timing fields;
- a display enable that needs both an enable bit and a power bit in the control word;
- the bits-per-pixel code and the selected data swap mode.

It keeps a raw interrupt status that event inputs set. Software clears that status by writing ones. The block also drives an interrupt line from the status bits that the mask leaves through.

Accesses to a 128-word sub-window go straight on to a separate palette storage block. The top eight words of the window return fixed identification bytes. The block raises a one-cycle resync pulse after any write to the control word or to the first two timing words, so downstream timing logic can restart.

Top module: `lcd_regbank`

## Requirements
- R1: During and after reset every stored word is zero. The outputs are then: display disabled, pixelsPerLine 16, linesPerPanel 1, busRdata 0, busErr 0, resyncPulse 0 and irqOut 0.
- R2: Words at byte offsets 0x000 to 0x01C hold timing words 0 to 3, the upper base, the lower base, the interrupt mask and the control word. A write updates the word at the clock edge. A read returns the word on busRdata in the cycle after the request. The mask keeps only its low IRQ_W bits.
- R3: pixelsPerLine is (timing0[7:2] + 1) × 16 and linesPerPanel is timing1[9:0] + 1. Both outputs are 11 bits wide.
- R4: dispEnable is 1 only while control bit 0 and control bit 11 are both 1.
- R5: bppCode is control bits [3:1]. swapMode follows this priority:
  - 1 when control bit 9 is set;
  - otherwise 2 when control bit 10 is set;
  - otherwise 0.
- R6: Each irqSet bit that is high at a clock edge sets the matching status bit. Offset 0x020 reads the raw status. Offset 0x024 reads the status ANDed with the mask. irqOut is high while any masked bit is set.
- R7: A write to offset 0x028 clears each status bit where the write data holds a 1. An irqSet bit that is high in the same cycle wins, and its status bit stays set.
- R8: Offsets 0x02C and 0x030 read the curUpper and curLower inputs.
- R9: Offsets 0xFE0 to 0xFFC read one identification byte per word, zero-extended, in the order 0x10, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: Accesses at offsets 0x200 to 0x3FC go to the palette block:
  - palSel follows the request in the same cycle, with palWr, palWdata and palAddr = offset[8:2];
  - a palette read returns palRdata on busRdata in the cycle after the request.
- R11: Some reads return 0 and pulse busErr for one cycle. These are reads of an undecoded offset, of offset 0x028, or of an address with bits [1:0] not zero. Writes to read-only or undecoded offsets change no stored state.
- R12: A write to timing0, timing1 or the control word raises resyncPulse for exactly the one cycle after the write. Writes to other offsets do not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus request valid |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 12 | Byte offset in the window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| busErr | output | 1 | One-cycle pulse after a bad read |
| palSel | output | 1 | Palette window access |
| palWr | output | 1 | Palette write |
| palAddr | output | 7 | Palette word index |
| palWdata | output | 32 | Palette write data |
| palRdata | input | 32 | Palette read data, one cycle after palSel |
| irqSet | input | IRQ_W | Interrupt event pulses |
| irqOut | output | 1 | Masked interrupt request |
| curUpper | input | 32 | Current upper frame address |
| curLower | input | 32 | Current lower frame address |
| pixelsPerLine | output | 11 | Decoded active pixels per line |
| linesPerPanel | output | 11 | Decoded lines per panel |
| dispEnable | output | 1 | Enable and power both set |
| bppCode | output | 3 | Bits-per-pixel code |
| swapMode | output | 2 | 0 none, 1 big-endian bytes, 2 big-endian pixels |
| timing2 | output | 32 | Timing word 2 |
| timing3 | output | 32 | Timing word 3 |
| upperBase | output | 32 | Upper panel base address |
| lowerBase | output | 32 | Lower panel base address |
| resyncPulse | output | 1 | Pulse after a timing or control write |

## Verification
Some rules are checked by assertions on every cycle:

- a status bit raised by an event is still set on the next cycle;
- a clear leaves no un-refreshed target bit set;
- the enable, busErr and resyncPulse outputs only rise after a matching bus transfer;
- palette forwarding never overlaps a register write.

Only the bench scenarios can show the values themselves: the decoded resolution numbers, the identification bytes, the swap-mode priority, readback of each word, and zero data on bad reads. The same holds for the absence of effects, such as writes to read-only offsets and writes to words that must not raise a resync.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

  localparam int IDX_T0    = 0;
  localparam int IDX_T1    = 1;
  localparam int IDX_MASK  = 6;
  localparam int IDX_CTRL  = 7;
  localparam int NUM_CFG   = 8;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_PWR  = 11;
  localparam int CTRL_BYTE = 9;
  localparam int CTRL_PIX  = 10;

  typedef enum logic [2:0] {
    SRC_CFG, SRC_RAW, SRC_MSK, SRC_CURU, SRC_CURL, SRC_ID, SRC_PAL, SRC_NONE
  } rdSrcE;

  typedef struct packed {
    logic [NUM_CFG-1:0] wrCfg;
    logic               wrClr;
    logic               rdEn;
    rdSrcE              rdSrc;
    logic [2:0]         rdIdx;
  } strobeT;

  function automatic logic [7:0] idByte(input logic [2:0] i);
    case (i)
      3'd0: idByte = 8'h10;
      3'd1: idByte = 8'h11;
      3'd2: idByte = 8'h04;
      3'd3: idByte = 8'h00;
      3'd4: idByte = 8'h0D;
      3'd5: idByte = 8'hF0;
      3'd6: idByte = 8'h05;
      default: idByte = 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/lcd_regbank_ctrl.sv
module lcd_regbank_ctrl
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAL_AW = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output strobeT            strb,
  output logic              palSel,
  output logic              palWr,
  output logic [PAL_AW-1:0] palAddr,
  output logic              busErr,
  output logic              resyncPulse
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             aligned;
  logic             inPal;
  logic             inId;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  // palette window 0x200..0x3FF, identification words 0xFE0..0xFFF
  assign inPal   = aligned && (busAddr[ADDR_W-1:PAL_AW+2] == 3'b001);
  assign inId    = aligned && (busAddr[ADDR_W-1:5] == 7'h7F);

  always_comb begin
    strb       = '0;
    strb.rdSrc = SRC_NONE;
    strb.rdIdx = busAddr[4:2];
    if (busSel && aligned && busWr) begin
      if (wordIdx < IDX_W'(NUM_CFG)) strb.wrCfg[busAddr[4:2]] = 1'b1;
      else if (wordIdx == IDX_W'(10)) strb.wrClr = 1'b1;
    end else if (busSel && !busWr) begin
      strb.rdEn = 1'b1;
      if (!aligned)                        strb.rdSrc = SRC_NONE;
      else if (wordIdx < IDX_W'(NUM_CFG))  strb.rdSrc = SRC_CFG;
      else if (wordIdx == IDX_W'(8))       strb.rdSrc = SRC_RAW;
      else if (wordIdx == IDX_W'(9))       strb.rdSrc = SRC_MSK;
      else if (wordIdx == IDX_W'(11))      strb.rdSrc = SRC_CURU;
      else if (wordIdx == IDX_W'(12))      strb.rdSrc = SRC_CURL;
      else if (inPal)                      strb.rdSrc = SRC_PAL;
      else if (inId)                       strb.rdSrc = SRC_ID;
    end
  end

  assign palSel  = busSel && inPal;
  assign palWr   = busWr;
  assign palAddr = busAddr[PAL_AW+1:2];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busErr      <= 1'b0;
      resyncPulse <= 1'b0;
    end else begin
      busErr      <= strb.rdEn && (strb.rdSrc == SRC_NONE);
      resyncPulse <= strb.wrCfg[IDX_T0] || strb.wrCfg[IDX_T1] || strb.wrCfg[IDX_CTRL];
    end
  end

  // R11: an error pulse only follows a read request
  a_r11_err_after_read: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(busSel && !busWr));

  // R12: a resync pulse only follows a write request
  a_r12_resync_after_write: assert property (@(posedge clk) disable iff (!rstN)
    resyncPulse |-> $past(busSel && busWr));

  // R10: palette forwarding never coincides with a register write strobe
  a_r10_pal_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({palSel, |strb.wrCfg, strb.wrClr}));

endmodule

// File: rtl/lcd_regbank_dp.sv
module lcd_regbank_dp
  import lcd_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 4,
  parameter int RES_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [IRQ_W-1:0]  irqSet,
  input  logic [DATA_W-1:0] curUpper,
  input  logic [DATA_W-1:0] curLower,
  input  logic [DATA_W-1:0] palRdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic [RES_W-1:0]  pixelsPerLine,
  output logic [RES_W-1:0]  linesPerPanel,
  output logic              dispEnable,
  output logic [2:0]        bppCode,
  output logic [1:0]        swapMode,
  output logic [DATA_W-1:0] timing2,
  output logic [DATA_W-1:0] timing3,
  output logic [DATA_W-1:0] upperBase,
  output logic [DATA_W-1:0] lowerBase
);

  logic [DATA_W-1:0] cfgQ [NUM_CFG];
  logic [IRQ_W-1:0]  statusQ;
  logic [IRQ_W-1:0]  clrMask;
  logic [DATA_W-1:0] rdNext;
  logic [DATA_W-1:0] rdQ;
  logic              palQ;

  for (genvar g = 0; g < NUM_CFG; g++) begin : gCfg
    if (g == IDX_MASK) begin : gMask
      always_ff @(posedge clk) begin
        if (!rstN)             cfgQ[g] <= '0;
        else if (strb.wrCfg[g]) cfgQ[g] <= DATA_W'(busWdata[IRQ_W-1:0]);
      end
    end else begin : gFull
      always_ff @(posedge clk) begin
        if (!rstN)             cfgQ[g] <= '0;
        else if (strb.wrCfg[g]) cfgQ[g] <= busWdata;
      end
    end
  end

  // raise beats clear when both hit the same bit
  assign clrMask = strb.wrClr ? busWdata[IRQ_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statusQ <= '0;
    else       statusQ <= (statusQ & ~clrMask) | irqSet;
  end

  always_comb begin
    case (strb.rdSrc)
      SRC_CFG:  rdNext = cfgQ[strb.rdIdx];
      SRC_RAW:  rdNext = DATA_W'(statusQ);
      SRC_MSK:  rdNext = DATA_W'(statusQ & cfgQ[IDX_MASK][IRQ_W-1:0]);
      SRC_CURU: rdNext = curUpper;
      SRC_CURL: rdNext = curLower;
      SRC_ID:   rdNext = DATA_W'(idByte(strb.rdIdx));
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ  <= '0;
      palQ <= 1'b0;
    end else begin
      rdQ  <= strb.rdEn ? rdNext : '0;
      palQ <= strb.rdEn && (strb.rdSrc == SRC_PAL);
    end
  end

  assign busRdata      = palQ ? palRdata : rdQ;
  assign irqOut        = |(statusQ & cfgQ[IDX_MASK][IRQ_W-1:0]);
  assign pixelsPerLine = (RES_W'(cfgQ[IDX_T0][7:2]) + RES_W'(1)) << 4;
  assign linesPerPanel = RES_W'(cfgQ[IDX_T1][9:0]) + RES_W'(1);
  assign dispEnable    = cfgQ[IDX_CTRL][CTRL_EN] && cfgQ[IDX_CTRL][CTRL_PWR];
  assign bppCode       = cfgQ[IDX_CTRL][3:1];
  assign swapMode      = cfgQ[IDX_CTRL][CTRL_BYTE] ? 2'd1 :
                         cfgQ[IDX_CTRL][CTRL_PIX]  ? 2'd2 : 2'd0;
  assign timing2       = cfgQ[2];
  assign timing3       = cfgQ[3];
  assign upperBase     = cfgQ[4];
  assign lowerBase     = cfgQ[5];

  // R6: a raised event bit is visible in the status on the next cycle
  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (|irqSet) |=> ((statusQ & $past(irqSet)) == $past(irqSet)));

  // R7: a clear leaves no targeted bit set unless an event refreshed it
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrClr |=> ((statusQ & $past(busWdata[IRQ_W-1:0]) & ~$past(irqSet)) == '0));

  // R4: the display only turns on through a control write
  a_r4_enable_by_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dispEnable) |-> $past(strb.wrCfg[IDX_CTRL]));

  // R2: stored words hold still without a write strobe
  a_r2_base_stable: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrCfg[4]) |-> $stable(upperBase));

endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IRQ_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [11:0]       busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busErr,
  output logic              palSel,
  output logic              palWr,
  output logic [6:0]        palAddr,
  output logic [DATA_W-1:0] palWdata,
  input  logic [DATA_W-1:0] palRdata,
  input  logic [IRQ_W-1:0]  irqSet,
  output logic              irqOut,
  input  logic [DATA_W-1:0] curUpper,
  input  logic [DATA_W-1:0] curLower,
  output logic [10:0]       pixelsPerLine,
  output logic [10:0]       linesPerPanel,
  output logic              dispEnable,
  output logic [2:0]        bppCode,
  output logic [1:0]        swapMode,
  output logic [DATA_W-1:0] timing2,
  output logic [DATA_W-1:0] timing3,
  output logic [DATA_W-1:0] upperBase,
  output logic [DATA_W-1:0] lowerBase,
  output logic              resyncPulse
);

  strobeT strb;

  assign palWdata = busWdata;

  lcd_regbank_ctrl #(.ADDR_W(12), .PAL_AW(7)) u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .strb(strb), .palSel(palSel), .palWr(palWr), .palAddr(palAddr),
    .busErr(busErr), .resyncPulse(resyncPulse)
  );

  lcd_regbank_dp #(.DATA_W(DATA_W), .IRQ_W(IRQ_W), .RES_W(11)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata), .irqSet(irqSet),
    .curUpper(curUpper), .curLower(curLower), .palRdata(palRdata),
    .busRdata(busRdata), .irqOut(irqOut), .pixelsPerLine(pixelsPerLine),
    .linesPerPanel(linesPerPanel), .dispEnable(dispEnable), .bppCode(bppCode),
    .swapMode(swapMode), .timing2(timing2), .timing3(timing3),
    .upperBase(upperBase), .lowerBase(lowerBase)
  );

endmodule

// File: tb/lcd_regbank_bench.sv
module lcd_regbank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busErr, palSel, palWr, irqOut, dispEnable, resyncPulse;
  logic [6:0]  palAddr;
  logic [31:0] palWdata, palRd = '0;
  logic [3:0]  irqSet = '0;
  logic [31:0] curUpper = 32'hDEAD_0000, curLower = 32'h0000_BEEF;
  logic [10:0] pixelsPerLine, linesPerPanel;
  logic [2:0]  bppCode;
  logic [1:0]  swapMode;
  logic [31:0] timing2, timing3, upperBase, lowerBase;

  int nChk = 0;
  int nBad = 0;

  always #2 clk = ~clk;

  // palette model: answers one cycle after a read request
  always @(posedge clk) if (palSel && !palWr) palRd <= 32'hA500_0000 | 32'(palAddr);

  lcd_regbank u_lcd_regbank (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busErr(busErr), .palSel(palSel),
    .palWr(palWr), .palAddr(palAddr), .palWdata(palWdata), .palRdata(palRd),
    .irqSet(irqSet), .irqOut(irqOut), .curUpper(curUpper), .curLower(curLower),
    .pixelsPerLine(pixelsPerLine), .linesPerPanel(linesPerPanel),
    .dispEnable(dispEnable), .bppCode(bppCode), .swapMode(swapMode),
    .timing2(timing2), .timing3(timing3), .upperBase(upperBase),
    .lowerBase(lowerBase), .resyncPulse(resyncPulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, return at the next falling edge
  task automatic cyc(input logic s, input logic w, input logic [11:0] a,
                     input logic [31:0] d, input logic [3:0] irq);
    busSel = s; busWr = w; busAddr = a; busWdata = d; irqSet = irq;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; irqSet = '0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    cyc(1'b1, 1'b1, a, d, 4'h0);
  endtask

  task automatic rd(input string req, input logic [11:0] a, input logic [31:0] exp);
    cyc(1'b1, 1'b0, a, 32'h0, 4'h0);
    chk(req, busRdata, exp);
  endtask

  // {write, offset, data, expected read}
  localparam int NV = 22;
  localparam logic [76:0] VEC [NV] = '{
    {1'b1, 12'h000, 32'h0000_00FC, 32'h0}, {1'b0, 12'h000, 32'h0, 32'h0000_00FC},
    {1'b1, 12'h004, 32'h0000_03FF, 32'h0}, {1'b0, 12'h004, 32'h0, 32'h0000_03FF},
    {1'b1, 12'h008, 32'h1234_5678, 32'h0}, {1'b0, 12'h008, 32'h0, 32'h1234_5678},
    {1'b1, 12'h00C, 32'h9ABC_DEF0, 32'h0}, {1'b0, 12'h00C, 32'h0, 32'h9ABC_DEF0},
    {1'b1, 12'h010, 32'h8000_0000, 32'h0}, {1'b0, 12'h010, 32'h0, 32'h8000_0000},
    {1'b1, 12'h014, 32'h0010_0000, 32'h0}, {1'b0, 12'h014, 32'h0, 32'h0010_0000},
    {1'b1, 12'h018, 32'hFFFF_FFFF, 32'h0}, {1'b0, 12'h018, 32'h0, 32'h0000_000F},
    {1'b0, 12'hFE0, 32'h0, 32'h10}, {1'b0, 12'hFE4, 32'h0, 32'h11},
    {1'b0, 12'hFE8, 32'h0, 32'h04}, {1'b0, 12'hFEC, 32'h0, 32'h00},
    {1'b0, 12'hFF0, 32'h0, 32'h0D}, {1'b0, 12'hFF4, 32'h0, 32'hF0},
    {1'b0, 12'hFF8, 32'h0, 32'h05}, {1'b0, 12'hFFC, 32'h0, 32'hB1}
  };

  initial begin
    #(4 * 100000);
    nChk++; nBad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 rdata", busRdata, 32'h0);
    chk("R1 enable", 32'(dispEnable), 32'h0);
    chk("R1 ppl", 32'(pixelsPerLine), 32'd16);
    chk("R1 lpp", 32'(linesPerPanel), 32'd1);
    chk("R1 err/resync/irq", {29'h0, busErr, resyncPulse, irqOut}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 and R9: table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else rd(VEC[i][75:64] >= 12'hFE0 ? "R9 id" : "R2 readback", VEC[i][75:64], VEC[i][31:0]);
    end
    chk("R2 upperBase", upperBase, 32'h8000_0000);
    chk("R2 timing3", timing3, 32'h9ABC_DEF0);

    // R3: resolution decode
    chk("R3 ppl max", 32'(pixelsPerLine), 32'd1024);
    chk("R3 lpp max", 32'(linesPerPanel), 32'd1024);
    wr(12'h000, 32'hFFFF_FF28);
    chk("R3 ppl mid", 32'(pixelsPerLine), 32'd176);
    wr(12'h004, 32'hFFFF_FC00);
    chk("R3 lpp min", 32'(linesPerPanel), 32'd1);

    // R4: enable needs both bits
    wr(12'h01C, 32'h0000_0001);
    chk("R4 en only", 32'(dispEnable), 32'h0);
    wr(12'h01C, 32'h0000_0800);
    chk("R4 pwr only", 32'(dispEnable), 32'h0);
    wr(12'h01C, 32'h0000_0801);
    chk("R4 both", 32'(dispEnable), 32'h1);

    // R5: bpp and swap priority
    wr(12'h01C, 32'h0000_060A);
    chk("R5 bpp", 32'(bppCode), 32'd5);
    chk("R5 byte wins", 32'(swapMode), 32'd1);
    wr(12'h01C, 32'h0000_0404);
    chk("R5 pixel", 32'(swapMode), 32'd2);
    chk("R5 bpp2", 32'(bppCode), 32'd2);
    wr(12'h01C, 32'h0);
    chk("R5 none", 32'(swapMode), 32'd0);

    // R6: status set, raw and masked views
    wr(12'h018, 32'h5);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 4'b0110);
    chk("R6 irqOut", 32'(irqOut), 32'h1);
    rd("R6 raw", 12'h020, 32'h6);
    rd("R6 masked", 12'h024, 32'h4);

    // R7: write-one-to-clear, set wins
    wr(12'h028, 32'h4);
    chk("R7 irqOut low", 32'(irqOut), 32'h0);
    rd("R7 after clear", 12'h020, 32'h2);
    cyc(1'b1, 1'b1, 12'h028, 32'h2, 4'b0010);
    rd("R7 set wins", 12'h020, 32'h2);
    wr(12'h028, 32'hF);
    rd("R7 all clear", 12'h020, 32'h0);

    // R8: current addresses
    rd("R8 upper", 12'h02C, 32'hDEAD_0000);
    rd("R8 lower", 12'h030, 32'h0000_BEEF);

    // R10: palette forwarding
    busSel = 1'b1; busWr = 1'b1; busAddr = 12'h204; busWdata = 32'h77;
    #1;
    chk("R10 pal write", {palSel, palWr, 23'h0, palAddr}, {1'b1, 1'b1, 23'h0, 7'd1});
    chk("R10 pal wdata", palWdata, 32'h77);
    @(posedge clk); @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    rd("R10 pal read", 12'h3FC, 32'hA500_007F);
    chk("R10 no err", 32'(busErr), 32'h0);

    // R11: bad reads and ignored writes
    rd("R11 undecoded data", 12'h100, 32'h0);
    chk("R11 err pulse", 32'(busErr), 32'h1);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 4'h0);
    chk("R11 err one cycle", 32'(busErr), 32'h0);
    rd("R11 misaligned", 12'h002, 32'h0);
    chk("R11 misaligned err", 32'(busErr), 32'h1);
    rd("R11 clear read", 12'h028, 32'h0);
    chk("R11 clear read err", 32'(busErr), 32'h1);
    wr(12'h020, 32'hF);
    rd("R11 status untouched", 12'h020, 32'h0);
    wr(12'hFE0, 32'hFF);
    rd("R11 id untouched", 12'hFE0, 32'h10);
    wr(12'h011, 32'h1);
    rd("R11 misaligned write", 12'h010, 32'h8000_0000);

    // R12: resync pulse
    wr(12'h000, 32'h0);
    chk("R12 pulse t0", 32'(resyncPulse), 32'h1);
    cyc(1'b0, 1'b0, 12'h0, 32'h0, 4'h0);
    chk("R12 one cycle", 32'(resyncPulse), 32'h0);
    wr(12'h01C, 32'h1);
    chk("R12 pulse ctrl", 32'(resyncPulse), 32'h1);
    wr(12'h010, 32'h1);
    chk("R12 base no pulse", 32'(resyncPulse), 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule